// File: doc/BRIEF.md
# Transmit Fatal-Exception Interrupt Controller

This block gathers eight single-cycle exception pulses raised by a transmit interface and records each one in a sticky status register. Software clears a recorded exception by writing a one to its bit. A per-bit interrupt enable register decides which recorded exceptions drive the system interrupt line.

A second per-bit register classes exceptions as fatal. When an exception that is classed as fatal fires, the block sets a summary bit (status bit 8) and asserts `trainHold`. That output tells the transmit datapath to stop sending data and to send training patterns without a break. The halt stays in force until software turns the interface enable off and then on again. The summary bit clears together with the halt.

The register port is a plain single-cycle write strobe with a two-bit address. Read data is combinational on the address.

Top module: `txerr_irq_ctrl`

## Requirements
- R1: After reset, the following values hold: the status reads 0x000, the interrupt enable register reads 0x00, `irqOut` and `trainHold` are low, and the fatal-class register reads 0xAC. The value 0xAC sets bits 2, 3, 5 and 7, which are oversized burst, FIFO overflow, sync loss and framing threshold.
- R2: The exception bit order is fixed:
  - bit 0: calendar parity, bank 0
  - bit 1: calendar parity, bank 1
  - bit 2: burst over 512 KB
  - bit 3: data FIFO overflow
  - bit 4: DIP2 error
  - bit 5: sync loss after repeated DIP2 errors
  - bit 6: unexpected framing
  - bit 7: framing error threshold

  A pulse on `evtPulse[i]` sets status bit i on the next clock edge. The bit stays set after the pulse ends.
- R3: A write to address 0 clears every status bit 7..0 whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged.
- R4: If an exception pulse and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R5: `irqOut` is high exactly when some status bit 7..0 and the matching interrupt enable bit are both 1. This also holds when the enable is written after the status bit was already set.
- R6: An exception whose fatal-class bit is 1 sets status bit 8 and `trainHold` on the next edge. An exception whose fatal-class bit is 0 sets neither.
- R7: Status bit 8 and `trainHold` ignore status writes, including a write of 0xFF. They stay set while `ifEnable` is low. They clear on the edge at which `ifEnable` is first sampled high after being sampled low.
- R8: If a fatal exception arrives in the same cycle as the re-enable edge, `trainHold` and status bit 8 stay set.
- R9: The register addresses are:
  - 0: status (9 bits)
  - 1: interrupt enable
  - 2: fatal class
  - 3: reads 0, and writes to it change nothing

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 8 | Exception pulses, one bit per exception |
| ifEnable | input | 1 | Interface enable level from software |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 9 | Register read data for `regAddr` |
| irqOut | output | 1 | System interrupt |
| trainHold | output | 1 | Datapath halted, send continuous training |

## Verification
The assertions check several properties on every cycle:
- recorded exceptions stay sticky unless a status write occurs;
- a pulsed exception is always captured, even when a clear of the same bit collides with it;
- a one-to-clear write leaves no bit it cleared still set;
- any fatal-class exception raises the halt on the next cycle;
- the halt never drops while the enable is low;
- the interrupt line is never raised with the enable register empty.

Some behaviours can only be shown by the directed scenarios:
- the reset values;
- the exact re-enable handshake that releases the halt;
- a fatal exception that collides with the re-enable edge;
- the register map, including the inert spare address and the read-only summary bit.

// File: rtl/txerr_pkg.sv
package txerr_pkg;
  localparam int EVT_N  = 8;
  localparam int REG_W  = EVT_N + 1;
  localparam int ADDR_W = 2;

  // exception bit positions (software decodes these)
  localparam int EVT_CALPAR0   = 0;
  localparam int EVT_CALPAR1   = 1;
  localparam int EVT_BURST_BIG = 2;
  localparam int EVT_FIFO_OVF  = 3;
  localparam int EVT_DIP_ERR   = 4;
  localparam int EVT_SYNC_LOST = 5;
  localparam int EVT_FRM_ODD   = 6;
  localparam int EVT_FRM_LIMIT = 7;

  localparam logic [EVT_N-1:0] FATAL_DEFAULT =
    EVT_N'((1 << EVT_BURST_BIG) | (1 << EVT_FIFO_OVF) |
           (1 << EVT_SYNC_LOST) | (1 << EVT_FRM_LIMIT));

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_IRQEN  = 2'd1,
    ADDR_FATAL  = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic [EVT_N-1:0] clrBits;
    logic             irqEnWr;
    logic             fatalWr;
    logic [EVT_N-1:0] wrBits;
    logic             rearm;
  } ctrlStrobe_t;
endpackage

// File: rtl/txerr_ctrl.sv
module txerr_ctrl
  import txerr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_N-1:0]  regWrData,
  input  logic              ifEnable,
  output ctrlStrobe_t       strobe
);
  logic enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= ifEnable;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrBits  = regWrData;
    strobe.rearm   = ifEnable & ~enPrev;
    if (regWrEn) begin
      case (regAddr_e'(regAddr))
        ADDR_STATUS: strobe.clrBits = regWrData;
        ADDR_IRQEN:  strobe.irqEnWr = 1'b1;
        ADDR_FATAL:  strobe.fatalWr = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/txerr_status.sv
module txerr_status
  import txerr_pkg::*;
#(
  parameter logic [EVT_N-1:0] FATAL_RST = FATAL_DEFAULT,
  parameter logic [EVT_N-1:0] IRQEN_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_N-1:0]  evtPulse,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqOut,
  output logic              trainHold,
  output logic [REG_W-1:0]  statusVec,
  output logic [EVT_N-1:0]  irqMaskVec,
  output logic [EVT_N-1:0]  syncMaskVec
);
  logic [EVT_N-1:0] stickyQ;
  logic [EVT_N-1:0] irqEnQ;
  logic [EVT_N-1:0] fatalQ;
  logic             holdQ;
  logic             fatalHit;

  for (genvar g = 0; g < EVT_N; g++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[g] <= 1'b0;
      else       stickyQ[g] <= (stickyQ[g] & ~strobe.clrBits[g]) | evtPulse[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= IRQEN_RST;
      fatalQ <= FATAL_RST;
    end else begin
      if (strobe.irqEnWr) irqEnQ <= strobe.wrBits;
      if (strobe.fatalWr) fatalQ <= strobe.wrBits;
    end
  end

  assign fatalHit = |(evtPulse & fatalQ);

  // a new fatal event beats a re-enable in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdQ <= 1'b0;
    else if (fatalHit)     holdQ <= 1'b1;
    else if (strobe.rearm) holdQ <= 1'b0;
  end

  always_comb begin
    case (regAddr_e'(regAddr))
      ADDR_STATUS: regRdData = {holdQ, stickyQ};
      ADDR_IRQEN:  regRdData = {1'b0, irqEnQ};
      ADDR_FATAL:  regRdData = {1'b0, fatalQ};
      default:     regRdData = '0;
    endcase
  end

  assign irqOut      = |(stickyQ & irqEnQ);
  assign trainHold   = holdQ;
  assign statusVec   = {holdQ, stickyQ};
  assign irqMaskVec  = irqEnQ;
  assign syncMaskVec = fatalQ;
endmodule

// File: rtl/txerr_irq_ctrl.sv
module txerr_irq_ctrl
  import txerr_pkg::*;
#(
  parameter logic [EVT_N-1:0] FATAL_RST = FATAL_DEFAULT,
  parameter logic [EVT_N-1:0] IRQEN_RST = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic              ifEnable,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_N-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqOut,
  output logic              trainHold
);
  ctrlStrobe_t      strobe;
  logic [REG_W-1:0] statusVec;
  logic [EVT_N-1:0] irqMaskVec;
  logic [EVT_N-1:0] syncMaskVec;

  txerr_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .ifEnable  (ifEnable),
    .strobe    (strobe)
  );

  txerr_status #(
    .FATAL_RST (FATAL_RST),
    .IRQEN_RST (IRQEN_RST)
  ) uStatus (
    .clk         (clk),
    .rstN        (rstN),
    .evtPulse    (evtPulse),
    .strobe      (strobe),
    .regAddr     (regAddr),
    .regRdData   (regRdData),
    .irqOut      (irqOut),
    .trainHold   (trainHold),
    .statusVec   (statusVec),
    .irqMaskVec  (irqMaskVec),
    .syncMaskVec (syncMaskVec)
  );
endmodule

// File: rtl/txerr_irq_chk.sv
module txerr_irq_chk
  import txerr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [EVT_N-1:0]  evtPulse,
  input logic              ifEnable,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [EVT_N-1:0]  regWrData,
  input logic              irqOut,
  input logic              trainHold,
  input logic [REG_W-1:0]  statusVec,
  input logic [EVT_N-1:0]  irqMaskVec,
  input logic [EVT_N-1:0]  syncMaskVec
);
  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusVec[EVT_N-1:0] & $past(evtPulse)) == $past(evtPulse))); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 2'd0) |=>
      ((statusVec[EVT_N-1:0] & $past(statusVec[EVT_N-1:0])) == $past(statusVec[EVT_N-1:0]))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |=>
      ((statusVec[EVT_N-1:0] & $past(regWrData & ~evtPulse)) == '0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (irqMaskVec == '0) |-> !irqOut); // R5

  AST_FATAL_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtPulse & syncMaskVec)) |=> (trainHold && statusVec[EVT_N])); // R6

  AST_HOLD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (trainHold && !ifEnable) |=> trainHold); // R7
endmodule

bind txerr_irq_ctrl txerr_irq_chk uChk (.*);

// File: tb/txerr_irq_ctrl_test.sv
module txerr_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtPulse = '0;
  logic       ifEnable = 1'b1;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [8:0] regRdData;
  logic       irqOut;
  logic       trainHold;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  txerr_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ifEnable(ifEnable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .trainHold(trainHold)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(logic [7:0] v);
    @(negedge clk) evtPulse = v;
    @(negedge clk) evtPulse = '0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk) begin regWrEn = 1'b1; regAddr = a; regWrData = d; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [8:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic expectReg(string req, logic [1:0] a, logic [8:0] exp);
    logic [8:0] v;
    rdReg(a, v);
    check(req, $sformatf("reg%0d", a), v, exp);
  endtask

  task automatic toggleEnable();
    @(negedge clk) ifEnable = 1'b0;
    @(negedge clk) ifEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    expectReg("R1", 2'd0, 9'h000);
    expectReg("R1", 2'd1, 9'h000);
    expectReg("R1", 2'd2, 9'h0AC);
    check("R1", "irqOut", irqOut, 0);
    check("R1", "trainHold", trainHold, 0);
  endtask

  task automatic tLatch();
    pulse(8'h01);
    expectReg("R2", 2'd0, 9'h001);
    repeat (3) @(negedge clk);
    expectReg("R2", 2'd0, 9'h001);
    pulse(8'h40);
    expectReg("R2", 2'd0, 9'h041);
    check("R6", "non-fatal no hold", trainHold, 0);
    check("R5", "irq masked", irqOut, 0);
  endtask

  task automatic tW1C();
    wrReg(2'd0, 8'h01);
    expectReg("R3", 2'd0, 9'h040);
    wrReg(2'd0, 8'h00);
    expectReg("R3", 2'd0, 9'h040);
    wrReg(2'd0, 8'h40);
    expectReg("R3", 2'd0, 9'h000);
  endtask

  task automatic tClearRace();
    pulse(8'h10);
    @(negedge clk) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h10; evtPulse = 8'h10; end
    @(negedge clk) begin regWrEn = 1'b0; evtPulse = '0; end
    expectReg("R4", 2'd0, 9'h010);
    wrReg(2'd0, 8'h10);
    expectReg("R4", 2'd0, 9'h000);
  endtask

  task automatic tIrq();
    wrReg(2'd1, 8'h02);
    expectReg("R9", 2'd1, 9'h002);
    pulse(8'h01);
    check("R5", "unmasked bit no irq", irqOut, 0);
    pulse(8'h02);
    check("R5", "masked bit irq", irqOut, 1);
    wrReg(2'd0, 8'h02);
    check("R5", "irq drops on clear", irqOut, 0);
    wrReg(2'd1, 8'h03);
    check("R5", "late enable irq", irqOut, 1);
    wrReg(2'd0, 8'hFF);
    check("R5", "irq after clear all", irqOut, 0);
  endtask

  task automatic tFatal();
    pulse(8'h04);
    expectReg("R6", 2'd0, 9'h104);
    check("R6", "trainHold", trainHold, 1);
    wrReg(2'd0, 8'hFF);
    expectReg("R7", 2'd0, 9'h100);
    check("R7", "hold after W1C", trainHold, 1);
  endtask

  task automatic tRelease();
    @(negedge clk) ifEnable = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", "hold while disabled", trainHold, 1);
    expectReg("R7", 2'd0, 9'h100);
    ifEnable = 1'b1;
    @(negedge clk);
    check("R7", "hold after re-enable", trainHold, 0);
    expectReg("R7", 2'd0, 9'h000);
  endtask

  task automatic tSyncMask();
    wrReg(2'd2, 8'h01);
    expectReg("R9", 2'd2, 9'h001);
    pulse(8'h04);
    check("R6", "unclassed no hold", trainHold, 0);
    expectReg("R6", 2'd0, 9'h004);
    pulse(8'h01);
    check("R6", "classed hold", trainHold, 1);
    expectReg("R6", 2'd0, 9'h105);
  endtask

  task automatic tRearmRace();
    @(negedge clk) ifEnable = 1'b0;
    @(negedge clk) begin ifEnable = 1'b1; evtPulse = 8'h01; end
    @(negedge clk) evtPulse = '0;
    check("R8", "hold kept", trainHold, 1);
    expectReg("R8", 2'd0, 9'h105);
    toggleEnable();
    check("R8", "later release", trainHold, 0);
  endtask

  task automatic tSpare();
    wrReg(2'd3, 8'hFF);
    expectReg("R9", 2'd3, 9'h000);
    expectReg("R9", 2'd1, 9'h003);
    expectReg("R9", 2'd2, 9'h001);
    expectReg("R9", 2'd0, 9'h005);
  endtask

  function automatic void summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLatch();
    tW1C();
    tClearRace();
    tIrq();
    tFatal();
    tRelease();
    tSyncMask();
    tRearmRace();
    tSpare();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule